// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Resolver

This block picks one winner among twenty-one pending service requests of a small 8-bit controller and presents it as a registered source index with a valid flag. The sources fall into two tiers. The upper tier holds the three reset causes (power-on or external reset, clock-monitor failure, watchdog timeout), the non-maskable external interrupt, the illegal-opcode trap and the software trap. The lower tier holds fifteen maskable peripheral requests. The upper tier is strictly ordered and always beats the lower tier.

Inside the maskable tier a 4-bit select field, written over a simple configuration write port, lifts any one source above all the other maskable sources. The remaining sources keep their default order. Two mask inputs gate requests. The interrupt mask silences the whole maskable tier. A separate mask silences only the non-maskable external interrupt. The external IRQ line is active low. It can be sampled as a level, which is the reset default and suits wired-OR sharing. Through a configuration bit it can instead be sampled as a latched falling edge, which the CPU clears with an acknowledge pulse.

The winner output is a valid-only stream with no ready input. It cannot be back-pressured. Each cycle it states the winner of the requests sampled at the previous rising edge. A consumer that is not ready simply samples it later, because a request stays pending until its source or the acknowledge removes it.

Top module: `intr_prio_resolver`

## Requirements
- R1: Reset causes beat every other source in the fixed order power-on/external reset (index 0), clock monitor (index 1), watchdog (index 2), and no mask input affects them.
- R2: Below the reset causes come the external non-maskable interrupt (index 3), the illegal-opcode trap (index 4) and the software trap (index 5), in that order, and each of them beats every maskable source.
- R3: With no promotion, the maskable tier is ordered by ascending index: IRQ 6, real-time tick 7, input captures 1..3 at 8..10, output compares 1..4 at 11..14, shared capture-4/compare-5 at 15, timer overflow 16, pulse-accumulator overflow 17, pulse-accumulator edge 18, SPI done 19, serial-port system 20. per_req bit k is the request of index 7+k.
- R4: A select code promotes one maskable source above the rest of its tier. Code 0110 selects index 6, and codes 0111 to 1111 select indices 7 to 15. Codes 0000 to 0100 select indices 16 to 20. All unpromoted sources keep the R3 order.
- R5: Select code 0101 promotes nothing and leaves the R3 order. After reset the select field holds 0110, which puts IRQ at the top of the maskable tier.
- R6: While i_mask is high every maskable request is ignored. While x_mask is high only the external non-maskable interrupt (index 3) is ignored. Reset causes and the two traps are never masked.
- R7: win_valid and win_idx reflect the requests, masks and configuration sampled at the previous rising clock edge. When nothing qualifies, win_valid is 0 and win_idx is 0. Both outputs read 0 during reset.
- R8: In level mode (cfg bit 4 = 0, the reset default), IRQ is pending in every cycle in which irq_n is low.
- R9: In edge mode (cfg bit 4 = 1), a high-to-low change of irq_n makes IRQ pending and latches it. The latch holds after irq_n returns high, and a steady low does not re-arm it. An ack_valid pulse with ack_idx = 6 clears it in the same cycle. An acknowledge of any other index leaves it set. A falling edge in the same cycle as the acknowledge keeps IRQ pending.
- R10: When cfg_we is high, cfg_wdata[3:0] is loaded as the select field and cfg_wdata[4] as the edge-mode bit. The new values govern arbitration from the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_req | input | 1 | Power-on or external reset request (index 0) |
| cmon_req | input | 1 | Clock-monitor failure request (index 1) |
| wdog_req | input | 1 | Watchdog timeout request (index 2) |
| xirq_req | input | 1 | Non-maskable external interrupt request (index 3) |
| illop_req | input | 1 | Illegal-opcode trap request (index 4) |
| swi_req | input | 1 | Software trap request (index 5) |
| irq_n | input | 1 | External IRQ line, active low (index 6) |
| per_req | input | 14 | Peripheral requests; bit k is index 7+k |
| i_mask | input | 1 | Masks the whole maskable tier |
| x_mask | input | 1 | Masks the non-maskable external interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | [3:0] select code, [4] IRQ edge mode |
| ack_valid | input | 1 | CPU acknowledge pulse |
| ack_idx | input | 5 | Index being acknowledged |
| win_valid | output | 1 | A winner is present |
| win_idx | output | 5 | Winning source index, 0 when none |

## Verification
The bench stacks requests from both tiers so that a wrong tier boundary or an inverted encoder order shows up as a lower-priority index winning. It promotes sources from both halves of the code map and uses the unused code. A decoder that is off by one, or that forgets the wrap from 0000 to index 16, would then raise the wrong source or disturb the default order. Mask cases check that the external-interrupt mask spares the software trap and that the maskable mask spares the external interrupt. In edge mode the bench acknowledges the wrong index, holds the line low past an acknowledge, and makes an edge coincide with an acknowledge. A latch that ignores the index, re-arms on level, or lets the clear win would each report a wrong winner.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
  localparam int unsigned NUM_RST = 3;
  localparam int unsigned NUM_NMI = 6;
  localparam int unsigned NUM_MSK = 15;
  localparam int unsigned NUM_SRC = NUM_NMI + NUM_MSK;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned PER_W   = NUM_MSK - 1;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned CFG_W   = SEL_W + 1;

  localparam int unsigned SRC_XIRQ = NUM_RST;
  localparam int unsigned SRC_IRQ  = NUM_NMI;

  localparam logic [SEL_W-1:0] SEL_IRQ_CODE = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_NONE     = 4'b0101;

  typedef logic [IDX_W-1:0] src_idx_t;
  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    logic             edge_mode;
    logic [SEL_W-1:0] sel;
  } prio_cfg_t;

  typedef struct packed {
    logic     hit;
    src_idx_t idx;
  } promo_t;

  // Codes at or above the IRQ code walk the tier from its head; lower codes
  // wrap onto its tail, so every maskable source has exactly one code.
  function automatic promo_t promo_decode(input logic [SEL_W-1:0] code);
    promo_t r;
    int     off;
    r.hit = 1'b0;
    r.idx = '0;
    if (code != SEL_NONE) begin
      if (code >= SEL_IRQ_CODE) off = int'(code) - int'(SEL_IRQ_CODE);
      else                      off = int'(code) + (2**SEL_W) - int'(SEL_IRQ_CODE);
      if (off < int'(NUM_MSK)) begin
        r.hit = 1'b1;
        r.idx = src_idx_t'(int'(NUM_NMI) + off);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/intr_cfg_reg.sv
module intr_cfg_reg
  import intr_prio_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_INIT  = SEL_IRQ_CODE,
  parameter logic             EDGE_INIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output prio_cfg_t        cfg,
  output promo_t           promo
);
  prio_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.sel       <= SEL_INIT;
      cfg_q.edge_mode <= EDGE_INIT;
    end else if (cfg_we) begin
      cfg_q <= prio_cfg_t'(cfg_wdata);
    end
  end

  assign cfg   = cfg_q;
  assign promo = promo_decode(cfg_q.sel);
endmodule

// File: rtl/intr_req_cond.sv
module intr_req_cond
  import intr_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_req,
  input  logic             cmon_req,
  input  logic             wdog_req,
  input  logic             xirq_req,
  input  logic             illop_req,
  input  logic             swi_req,
  input  logic             irq_n,
  input  logic [PER_W-1:0] per_req,
  input  logic             i_mask,
  input  logic             x_mask,
  input  logic             edge_mode,
  input  logic             ack_valid,
  input  src_idx_t         ack_idx,
  output src_vec_t         req_vec
);
  logic irq_prev;
  logic irq_flag;
  logic irq_fell;
  logic irq_ack;
  logic irq_pend;
  logic [NUM_MSK-1:0] msk_raw;

  assign irq_fell = edge_mode & irq_prev & ~irq_n;
  assign irq_ack  = ack_valid && (ack_idx == src_idx_t'(SRC_IRQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= 1'b1;
      irq_flag <= 1'b0;
    end else begin
      irq_prev <= irq_n;
      if (!edge_mode)    irq_flag <= 1'b0;
      else if (irq_fell) irq_flag <= 1'b1;
      else if (irq_ack)  irq_flag <= 1'b0;
    end
  end

  // A fresh edge outranks a clear arriving in the same cycle.
  assign irq_pend = edge_mode ? (irq_fell | (irq_flag & ~irq_ack)) : ~irq_n;

  assign req_vec[0]        = por_req;
  assign req_vec[1]        = cmon_req;
  assign req_vec[2]        = wdog_req;
  assign req_vec[SRC_XIRQ] = xirq_req & ~x_mask;
  assign req_vec[4]        = illop_req;
  assign req_vec[5]        = swi_req;

  assign msk_raw = {per_req, irq_pend};

  for (genvar g = 0; g < NUM_MSK; g++) begin : g_gate
    assign req_vec[NUM_NMI + g] = msk_raw[g] & ~i_mask;
  end
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
  import intr_prio_pkg::*;
(
  input  src_vec_t req_vec,
  input  promo_t   promo,
  output logic     any,
  output src_idx_t pick_idx
);
  logic     nmi_hit;
  logic     msk_hit;
  logic     promo_take;
  src_idx_t nmi_idx;
  src_idx_t msk_idx;

  always_comb begin
    nmi_hit = 1'b0;
    nmi_idx = '0;
    for (int i = NUM_NMI - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        nmi_hit = 1'b1;
        nmi_idx = src_idx_t'(i);
      end
    end
  end

  always_comb begin
    msk_hit = 1'b0;
    msk_idx = '0;
    for (int i = NUM_SRC - 1; i >= int'(NUM_NMI); i--) begin
      if (req_vec[i]) begin
        msk_hit = 1'b1;
        msk_idx = src_idx_t'(i);
      end
    end
  end

  assign promo_take = promo.hit && req_vec[promo.idx];
  assign any        = nmi_hit | msk_hit;

  always_comb begin
    if (nmi_hit)         pick_idx = nmi_idx;
    else if (promo_take) pick_idx = promo.idx;
    else if (msk_hit)    pick_idx = msk_idx;
    else                 pick_idx = '0;
  end
endmodule

// File: rtl/intr_prio_resolver.sv
module intr_prio_resolver
  import intr_prio_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_INIT  = SEL_IRQ_CODE,
  parameter logic             EDGE_INIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_req,
  input  logic             cmon_req,
  input  logic             wdog_req,
  input  logic             xirq_req,
  input  logic             illop_req,
  input  logic             swi_req,
  input  logic             irq_n,
  input  logic [PER_W-1:0] per_req,
  input  logic             i_mask,
  input  logic             x_mask,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  prio_cfg_t cfg;
  promo_t    promo;
  src_vec_t  req_vec;
  logic      any;
  src_idx_t  pick_idx;

  intr_cfg_reg #(
    .SEL_INIT  (SEL_INIT),
    .EDGE_INIT (EDGE_INIT)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg),
    .promo     (promo)
  );

  intr_req_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_req   (por_req),
    .cmon_req  (cmon_req),
    .wdog_req  (wdog_req),
    .xirq_req  (xirq_req),
    .illop_req (illop_req),
    .swi_req   (swi_req),
    .irq_n     (irq_n),
    .per_req   (per_req),
    .i_mask    (i_mask),
    .x_mask    (x_mask),
    .edge_mode (cfg.edge_mode),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .req_vec   (req_vec)
  );

  intr_prio_pick u_pick (
    .req_vec  (req_vec),
    .promo    (promo),
    .any      (any),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
    end else begin
      win_valid <= any;
      win_idx   <= pick_idx;
    end
  end
endmodule

// File: rtl/intr_prio_checker.sv
module intr_prio_checker
  import intr_prio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             por_req,
  input logic             cmon_req,
  input logic             xirq_req,
  input logic             swi_req,
  input logic             i_mask,
  input logic             x_mask,
  input logic             win_valid,
  input logic [IDX_W-1:0] win_idx
);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> win_idx == '0);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_idx < src_idx_t'(NUM_SRC));

  assert_por_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> win_valid && win_idx == '0);

  assert_cmon_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmon_req && !por_req) |=> win_valid && win_idx == src_idx_t'(1));

  assert_swi_beats_tier_R2: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req |=> win_valid && win_idx < src_idx_t'(NUM_NMI));

  assert_imask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_idx >= src_idx_t'(NUM_NMI)) |-> $past(!i_mask));

  assert_xmask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_idx == src_idx_t'(SRC_XIRQ)) |-> $past(xirq_req && !x_mask));
endmodule

bind intr_prio_resolver intr_prio_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_req   (por_req),
  .cmon_req  (cmon_req),
  .xirq_req  (xirq_req),
  .swi_req   (swi_req),
  .i_mask    (i_mask),
  .x_mask    (x_mask),
  .win_valid (win_valid),
  .win_idx   (win_idx)
);

// File: tb/test_intr_prio_resolver.sv
module test_intr_prio_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_req = 0, cmon_req = 0, wdog_req = 0, xirq_req = 0;
  logic        illop_req = 0, swi_req = 0, irq_n = 1;
  logic [13:0] per_req = '0;
  logic        i_mask = 0, x_mask = 0, cfg_we = 0, ack_valid = 0;
  logic [4:0]  cfg_wdata = '0, ack_idx = '0;
  logic        win_valid;
  logic [4:0]  win_idx;

  typedef struct {
    string      tag;
    bit         v;
    logic [4:0] idx;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #4 clk = ~clk;

  intr_prio_resolver i_intr_prio_resolver (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .cmon_req(cmon_req),
    .wdog_req(wdog_req), .xirq_req(xirq_req), .illop_req(illop_req),
    .swi_req(swi_req), .irq_n(irq_n), .per_req(per_req), .i_mask(i_mask),
    .x_mask(x_mask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  task automatic quiet();
    por_req = 0; cmon_req = 0; wdog_req = 0; xirq_req = 0;
    illop_req = 0; swi_req = 0; irq_n = 1; per_req = '0;
    i_mask = 0; x_mask = 0; cfg_we = 0; ack_valid = 0; ack_idx = '0;
  endtask

  // Inputs were set at a falling edge; the next rising edge registers them.
  task automatic step(input string tag, input bit v, input logic [4:0] idx);
    exp_t e;
    e.tag = tag; e.v = v; e.idx = idx;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (win_valid !== e.v || win_idx !== e.idx) begin
        n_bad++;
        $display("FAIL %s: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
                 e.tag, win_valid, win_idx, e.v, e.idx);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: outputs stay clear during reset even with requests present
    por_req = 1; swi_req = 1; irq_n = 0;
    repeat (2) @(posedge clk);
    #2;
    n_vec++;
    if (win_valid !== 1'b0 || win_idx !== 5'd0) begin
      n_bad++;
      $display("FAIL R7 reset: got valid=%0d idx=%0d, expected valid=0 idx=0",
               win_valid, win_idx);
    end
    @(negedge clk);
    quiet();
    rst_n = 1;
    step("R7 idle", 0, 5'd0);

    // R1 reset causes
    por_req = 1; cmon_req = 1; wdog_req = 1; xirq_req = 1; swi_req = 1;
    irq_n = 0; per_req = '1; i_mask = 1; x_mask = 1;
    step("R1 por over all", 1, 5'd0);
    por_req = 0;
    step("R1 cmon next", 1, 5'd1);
    quiet(); wdog_req = 1; xirq_req = 1; i_mask = 1;
    step("R1 wdog over xirq", 1, 5'd2);

    // R2 non-maskable ordering
    quiet(); xirq_req = 1; illop_req = 1; swi_req = 1; irq_n = 0; per_req = '1;
    step("R2 xirq", 1, 5'd3);
    xirq_req = 0;
    step("R2 illop", 1, 5'd4);
    illop_req = 0;
    step("R2 swi over maskable", 1, 5'd5);

    // R3 / R8 default maskable order, level IRQ
    swi_req = 0;
    step("R3 R8 irq level top", 1, 5'd6);
    irq_n = 1;
    step("R3 rti", 1, 5'd7);
    per_req = 14'b0;
    per_req[13] = 1; per_req[9] = 1;
    step("R3 tof over sci", 1, 5'd16);

    // R6 masks
    quiet(); x_mask = 1; xirq_req = 1; swi_req = 1;
    step("R6 xmask spares swi", 1, 5'd5);
    swi_req = 0;
    step("R6 xmask blocks xirq", 0, 5'd0);
    quiet(); i_mask = 1; irq_n = 0; per_req = '1;
    step("R6 imask blocks tier", 0, 5'd0);
    xirq_req = 1;
    step("R6 imask spares xirq", 1, 5'd3);
    xirq_req = 0; illop_req = 1;
    step("R6 imask spares illop", 1, 5'd4);

    // R10 / R4 promotion
    quiet(); cfg_we = 1; cfg_wdata = 5'b0_0100;
    step("R10 write cycle idle", 0, 5'd0);
    cfg_we = 0; irq_n = 0; per_req = '1;
    step("R4 R10 sci promoted", 1, 5'd20);
    irq_n = 1; per_req = '0; per_req[0] = 1; per_req[12] = 1;
    step("R4 unpromoted keep order", 1, 5'd7);
    quiet(); cfg_we = 1; cfg_wdata = 5'b0_1111;
    step("R10 write ic4oc5", 0, 5'd0);
    cfg_we = 0; per_req[1] = 1; per_req[8] = 1;
    step("R4 ic4oc5 promoted", 1, 5'd15);
    quiet(); cfg_we = 1; cfg_wdata = 5'b0_0000;
    per_req[0] = 1; per_req[9] = 1;
    step("R4 write cycle old order", 1, 5'd7);
    cfg_we = 0;
    step("R4 code 0000 tof", 1, 5'd16);

    // R5 unused code
    quiet(); cfg_we = 1; cfg_wdata = 5'b0_0101;
    step("R10 write unused", 0, 5'd0);
    cfg_we = 0; per_req[1] = 1; per_req[8] = 1;
    step("R5 unused keeps order", 1, 5'd8);
    irq_n = 0; per_req[13] = 1;
    step("R5 irq first", 1, 5'd6);

    // R9 edge mode
    quiet(); cfg_we = 1; cfg_wdata = 5'b1_0110;
    step("R10 write edge", 0, 5'd0);
    cfg_we = 0; irq_n = 0;
    step("R9 fall", 1, 5'd6);
    irq_n = 1;
    step("R9 latched after rise", 1, 5'd6);
    ack_valid = 1; ack_idx = 5'd7;
    step("R9 other ack keeps", 1, 5'd6);
    ack_idx = 5'd6;
    step("R9 ack clears", 0, 5'd0);
    ack_valid = 0; irq_n = 0;
    step("R9 second fall", 1, 5'd6);
    ack_valid = 1; ack_idx = 5'd6;
    step("R9 ack with low line", 0, 5'd0);
    ack_valid = 0;
    step("R9 steady low ignored", 0, 5'd0);
    irq_n = 1;
    step("R9 rise idle", 0, 5'd0);
    irq_n = 0; ack_valid = 1; ack_idx = 5'd6;
    step("R9 fall beats ack", 1, 5'd6);
    ack_valid = 0;
    step("R9 kept after collision", 1, 5'd6);
    ack_valid = 1;
    step("R9 final clear", 0, 5'd0);

    // R8 back to level
    ack_valid = 0; cfg_we = 1; cfg_wdata = 5'b0_0110;
    step("R10 write level", 0, 5'd0);
    cfg_we = 0;
    step("R8 level low pending", 1, 5'd6);

    quiet();
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule